// File: doc/BRIEF.md
# ADC Sequence Controller with Low-Power Suspend

This block steps an external successive-approximation converter through a fixed run of four conversions. Each conversion starts with a single-cycle start pulse. The converter answers with a done pulse that carries 8-bit data, and the controller files that data into one of four result slots. When the fourth slot has been filled, a completion flag is raised. Software starts a run by writing to the control address. It reads the flag and the four results over a small register bus made of an address, a write strobe and a combinational read-data return. The bus carries no write data: a write strobe to the control address is the whole command.

While the system is in a stop or wait low-power state, the controller abandons the conversion it is running but keeps its place in the run. When the low-power request drops, the same slot is sampled again from the start, and the run goes on with the slots that remain.

A wait exit lets the next conversion start at once. A stop exit with the delay option low holds off the first conversion for a parameterised number of settling cycles. A stop exit with the delay option high inserts no hold-off.

The state machine has five states:
- `ST_IDLE`: no run active.
- `ST_ISSUE`: start pulse.
- `ST_WAIT`: waiting for done.
- `ST_SLEEP`: low power.
- `ST_SETTLE`: post-stop hold-off.

Its transitions are:
- control write: any state to `ST_ISSUE`.
- `ST_ISSUE` to `ST_WAIT` when not in low power, or to `ST_SLEEP` when in low power.
- `ST_WAIT` on done: to `ST_ISSUE`, or to `ST_IDLE` after the last slot.
- `ST_WAIT` to `ST_SLEEP` on a low-power request.
- `ST_SLEEP` on release: to `ST_SETTLE` after a stop with the delay option low, otherwise to `ST_ISSUE`.
- `ST_SETTLE` to `ST_ISSUE` when the count expires, or to `ST_SLEEP` on a new request.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `conv_start` stays low and a read of the control address (0x30) returns 0x00 until the first control write.
- R2: A write strobe to address 0x30 clears the completion flag and restarts the run at slot 0 from any state. `conv_start` is high in the cycle after the write.
- R3: `conv_start` is never high in two consecutive cycles. After a done that is accepted for a slot other than the last, the next `conv_start` comes in the following cycle.
- R4: The data of the accepted done for slot k (k = 0..3) is readable at address 0x31+k.
- R5: The completion flag reads as bit 7 of address 0x30, and bits 6..0 read as zero. The flag is set in the cycle after the done of slot 3 is accepted, and it stays set with no further `conv_start` until the next control write.
- R6: A write strobe to any of the addresses 0x31..0x34 changes no stored result and starts nothing.
- R7: While `stop_req` or `wait_req` is high, `conv_start` stays low and every `conv_done` is ignored.
- R8: A conversion cut off by low power is started again for the same slot after release. Its new data lands in that slot, and the run then continues with the later slots.
- R9: After a release in which only `wait_req` was seen, `conv_start` comes in the cycle after `wait_req` falls.
- R10: After a release in which `stop_req` was seen, with `dly_opt` low in the release cycle, `conv_start` comes `SETTLE_CYCLES` cycles later than the R9 case. With `dly_opt` high, it comes with no added delay.
- R11: A `conv_done` that coincides with a rising low-power request is discarded, and that slot is converted again after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe; 0x30 starts a run, other addresses are ignored |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| stop_req | input | 1 | Stop low-power state active (level) |
| wait_req | input | 1 | Wait low-power state active (level) |
| dly_opt | input | 1 | Stop-exit delay option; high means no settling hold-off |
| conv_start | output | 1 | One-cycle start to the converter |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | 8 | Converter result, valid with `conv_done` |

## Verification
A converter done pulse and the rising edge of a stop or wait request can fall in the same cycle. The bench provokes this by driving both on one clock edge at a random point in a run. It then judges the outcome in three ways:
- the slot read back after the run holds the data from the repeated conversion, not the data that came with the clashing done;
- `conv_start` comes again after release, with the delay that the stop, wait and `dly_opt` settings call for;
- the assertions confirm that no result is captured while a low-power request is high.

A control write that lands in the middle of a run is also exercised: the run must restart at slot 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SLEEP  = 3'd3,
        ST_SETTLE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/adc_seq_settle.sv
// Post-stop settling counter: loaded on release, counts down while running.
module adc_seq_settle #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CYCLES - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_bank.sv
// Result slot storage, one register per channel.
module adc_seq_bank #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] res_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (we && wr_idx == IDX_W'(g)) begin
                q <= wr_data;
            end
        end
        assign res_flat[g*DATA_W +: DATA_W] = q;
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencing state machine: issue, wait, sleep and settle.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             stop_req,
    input  logic             wait_req,
    input  logic             dly_opt,
    input  logic             conv_done,
    input  logic             settle_expired,
    output logic             conv_start,
    output logic             res_we,
    output logic [IDX_W-1:0] res_idx,
    output logic             seq_flag,
    output logic             settle_load,
    output logic             settle_run
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    seq_state_e state_q, state_d;
    logic       low_pwr;
    logic       saw_stop_q;
    logic [IDX_W-1:0] idx_q;
    logic       flag_q;

    assign low_pwr = stop_req | wait_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            state_d = ST_ISSUE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ISSUE:  state_d = low_pwr ? ST_SLEEP : ST_WAIT;
                ST_WAIT: begin
                    if (low_pwr)
                        state_d = ST_SLEEP;
                    else if (conv_done)
                        state_d = (idx_q == LAST_IDX) ? ST_IDLE : ST_ISSUE;
                end
                ST_SLEEP: begin
                    if (!low_pwr)
                        state_d = (saw_stop_q && !dly_opt) ? ST_SETTLE : ST_ISSUE;
                end
                ST_SETTLE: begin
                    if (low_pwr)
                        state_d = ST_SLEEP;
                    else if (settle_expired)
                        state_d = ST_ISSUE;
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        conv_start  = (state_q == ST_ISSUE) && !low_pwr && !ctrl_wr;
        res_we      = (state_q == ST_WAIT) && conv_done && !low_pwr && !ctrl_wr;
        settle_load = (state_q == ST_SLEEP) && !low_pwr && saw_stop_q && !dly_opt;
        settle_run  = (state_q == ST_SETTLE);
    end

    // sequence position, completion flag and stop memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            flag_q     <= 1'b0;
            saw_stop_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                idx_q  <= '0;
                flag_q <= 1'b0;
            end else if (res_we) begin
                if (idx_q == LAST_IDX)
                    flag_q <= 1'b1;
                else
                    idx_q <= idx_q + 1'b1;
            end
            if (state_q != ST_SLEEP)
                saw_stop_q <= stop_req;
            else if (stop_req)
                saw_stop_q <= 1'b1;
        end
    end

    assign res_idx  = idx_q;
    assign seq_flag = flag_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: four-slot conversion sequencer with low-power suspend.
module adc_seq_ctrl #(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 8,
    parameter int NUM_CH        = 4,
    parameter int CTRL_ADDR     = 'h30,
    parameter int RES_BASE      = 'h31,
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_req,
    input  logic              wait_req,
    input  logic              dly_opt,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic                     ctrl_wr;
    logic                     res_we;
    logic [IDX_W-1:0]         res_idx;
    logic                     seq_flag;
    logic                     settle_load;
    logic                     settle_run;
    logic                     settle_expired;
    logic [NUM_CH*DATA_W-1:0] res_flat;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    adc_seq_fsm #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_wr        (ctrl_wr),
        .stop_req       (stop_req),
        .wait_req       (wait_req),
        .dly_opt        (dly_opt),
        .conv_done      (conv_done),
        .settle_expired (settle_expired),
        .conv_start     (conv_start),
        .res_we         (res_we),
        .res_idx        (res_idx),
        .seq_flag       (seq_flag),
        .settle_load    (settle_load),
        .settle_run     (settle_run)
    );

    adc_seq_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .run     (settle_run),
        .expired (settle_expired)
    );

    adc_seq_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .we       (res_we),
        .wr_idx   (res_idx),
        .wr_data  (conv_data),
        .res_flat (res_flat)
    );

    // read mux: flag on control address, slots on consecutive addresses
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata[DATA_W-1] = seq_flag;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(RES_BASE + i))
                bus_rdata = res_flat[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int NUM_CH    = 4,
    parameter int CTRL_ADDR = 'h30
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic                     stop_req,
    input logic                     wait_req,
    input logic                     conv_start,
    input logic                     seq_flag,
    input logic                     res_we,
    input logic [NUM_CH*DATA_W-1:0] res_flat
);
    logic wr_ctrl;
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_quiet_lowpower_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req || wait_req) |-> !conv_start);

    p_no_capture_lowpower_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req || wait_req) |-> !res_we);

    p_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !seq_flag);

    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_flag && !wr_ctrl) |=> seq_flag);

    p_idle_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_flag && !wr_ctrl) |-> !conv_start);

    p_results_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_flag && !wr_ctrl) |=> $stable(res_flat));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_CH    (NUM_CH),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .stop_req   (stop_req),
    .wait_req   (wait_req),
    .conv_start (conv_start),
    .seq_flag   (seq_flag),
    .res_we     (res_we),
    .res_flat   (res_flat)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int SETTLE = 37;
    localparam logic [7:0] CTRL = 8'h30;
    localparam logic [7:0] BASE = 8'h31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       stop_req = 1'b0;
    logic       wait_req = 1'b0;
    logic       dly_opt = 1'b0;
    logic       conv_start;
    logic       conv_done = 1'b0;
    logic [7:0] conv_data = 8'h00;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_res [4];

    always #4 clk = ~clk;

    adc_seq_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .stop_req(stop_req), .wait_req(wait_req),
        .dly_opt(dly_opt), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_delay(input bit was_stop, input bit dly);
        return (was_stop && !dly) ? SETTLE : 0;
    endfunction

    task automatic wait_start(output int n);
        n = 0;
        @(negedge clk); #1;
        while (!conv_start && n < 5000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic ctrl_write();
        @(negedge clk);
        bus_addr = CTRL;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk(conv_start == 1'b1, "R2 start after control write", conv_start, 1);
        chk(bus_rdata[7] == 1'b0, "R2 flag cleared", bus_rdata[7], 0);
    endtask

    // entry: at a negedge where conv_start is high for slot idx
    task automatic conv_step(input int idx, input int mode_in);
        int mode = mode_in;
        int lat, hold, n;
        bit use_stop, dly;
        logic [7:0] d;
        forever begin
            @(negedge clk); #1;
            chk(conv_start == 1'b0, "R3 start is a single pulse", conv_start, 0);
            lat = $urandom_range(0, 3);
            repeat (lat) @(negedge clk);
            if (mode == 0) begin
                d = 8'($urandom);
                conv_done = 1'b1;
                conv_data = d;
                @(negedge clk);
                conv_done = 1'b0;
                exp_res[idx] = d;
                #1;
                if (idx < 3)
                    chk(conv_start == 1'b1, "R3 next start follows done", conv_start, 1);
                break;
            end
            use_stop = 1'($urandom % 2);
            if (use_stop) stop_req = 1'b1; else wait_req = 1'b1;
            if (mode == 2) begin
                conv_done = 1'b1;
                conv_data = 8'($urandom);   // R11: must be dropped
            end
            @(negedge clk);
            conv_done = 1'b0;
            #1;
            chk(conv_start == 1'b0, "R7 no start in low power", conv_start, 0);
            hold = $urandom_range(1, 5);
            for (int h = 0; h < hold; h++) begin
                conv_done = 1'($urandom % 2);     // R7 stray done ignored
                conv_data = 8'($urandom);
                @(negedge clk); #1;
                chk(conv_start == 1'b0, "R7 no start in low power", conv_start, 0);
            end
            dly = 1'($urandom % 2);
            conv_done = 1'b0;
            dly_opt = dly;
            stop_req = 1'b0;
            wait_req = 1'b0;
            wait_start(n);
            if (use_stop)
                chk(n == exp_delay(1'b1, dly), "R10 stop exit delay", n, exp_delay(1'b1, dly));
            else
                chk(n == exp_delay(1'b0, dly), "R9 wait exit delay", n, 0);
            mode = 0;   // R8: same slot converted again
        end
    endtask

    task automatic check_results();
        logic [7:0] a;
        bus_addr = CTRL;
        #1;
        chk(bus_rdata == 8'h80, "R5 flag set, low bits zero", bus_rdata, 8'h80);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bus_addr = BASE + 8'(i);
            #1;
            chk(bus_rdata == exp_res[i], "R4 R8 R11 slot contents", bus_rdata, exp_res[i]);
        end
        @(negedge clk);
        a = BASE + 8'($urandom % 4);
        bus_addr = a;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk(conv_start == 1'b0, "R6 result write starts nothing", conv_start, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bus_addr = BASE + 8'(i);
            #1;
            chk(bus_rdata == exp_res[i], "R6 result write ignored", bus_rdata, exp_res[i]);
        end
        repeat (3) begin
            @(negedge clk); #1;
            chk(conv_start == 1'b0, "R5 idle after completion", conv_start, 0);
        end
        bus_addr = CTRL;
        #1;
        chk(bus_rdata == 8'h80, "R5 flag held", bus_rdata, 8'h80);
    endtask

    task automatic run_seq(input int m0, input int m1, input int m2, input int m3);
        ctrl_write();
        conv_step(0, m0);
        conv_step(1, m1);
        conv_step(2, m2);
        conv_step(3, m3);
        check_results();
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            bus_addr = CTRL;
            #1;
            chk(conv_start == 1'b0, "R1 no start after reset", conv_start, 0);
            chk(bus_rdata == 8'h00, "R1 control reads zero", bus_rdata, 0);
        end
        // directed: plain, wait, stop with and without delay, coincident done
        run_seq(0, 0, 0, 0);
        run_seq(0, 1, 0, 0);
        run_seq(2, 0, 1, 2);
        run_seq(1, 1, 2, 1);
        // R2 restart mid-run
        ctrl_write();
        conv_step(0, 0);
        conv_step(1, 0);
        ctrl_write();
        conv_step(0, 0);
        conv_step(1, 0);
        conv_step(2, 0);
        conv_step(3, 0);
        check_results();
        // random runs
        for (int s = 0; s < 25; s++) begin
            run_seq($urandom_range(0, 2), $urandom_range(0, 2),
                    $urandom_range(0, 2), $urandom_range(0, 2));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule